// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs one external memory access at a time for a 16-bit processor core. It produces the pin-level timing of the access: the address latch strobe, the read strobe, a low/single write strobe, a high-byte write strobe and the active-low high-byte enable. It also drives a shared address/data bus with its output enable and samples that bus for read data. The sequencer advances once per half-period of the processor clock (TCL), so its `clk` runs at twice the processor rate and every count below is in `clk` cycles.

A requester pulses `req_valid` while the sequencer is idle, supplying the address, write data, byte enables, direction and a configuration for this access. The configuration selects:
- a multiplexed or a demultiplexed bus;
- a normal or an extended address-latch phase;
- a read/write delay;
- 0 to 15 wait states;
- 0 to 3 recovery units;
- single-write or per-byte write strobes;
- an 8-bit or a 16-bit bus.

When the access ends, `done` pulses for one cycle with `rdata` valid. The next request is issued after that pulse.

The FSM has four states:
- `ST_IDLE`: waiting for a request.
- `ST_ALE`: the address latch phase.
- `ST_STROBE`: the command region, including the optional delay slot.
- `ST_RECOV`: bus recovery.

Its transitions are:
- accept: `ST_IDLE` to `ST_ALE` when `req_valid` is high.
- latch_end: `ST_ALE` to `ST_STROBE` when the phase counter expires.
- cmd_end_recover: `ST_STROBE` to `ST_RECOV` when the counter expires and recovery is non-zero.
- cmd_end_finish: `ST_STROBE` to `ST_IDLE` when the counter expires and recovery is zero.
- recover_end: `ST_RECOV` to `ST_IDLE` when the counter expires.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: During and after reset, with no access in progress: `ale` = 0, `rd_n` = 1, `wr_lo_n` = 1, `wr_hi_n` = 1, `bhe_n` = 1, `ad_oe` = 0 and `done` = 0.
- R2: An access lasts L cycles, measured from the first `ale` cycle to the `done` cycle. L = B + 2·E + 2·W + 2·C, where B = 6 for a multiplexed bus and 4 for a demultiplexed bus, E is the extended-latch bit, W is the wait count and C is the recovery count.
- R3: `ale` goes high in the cycle after the accepting edge and stays high for 1 + 2·E cycles. No command strobe is active while `ale` is high.
- R4: The command region follows `ale` and lasts (5 for multiplexed, 3 for demultiplexed) + 2·W cycles. A read drives `rd_n` low from the first cycle of this region, or from the second cycle when the delay bit is set, to the end of the region. A write never drives `rd_n` low.
- R5: With `cfg_byte_wr` = 0 (single-write), every write drives `wr_lo_n` low in the R4 window, and `wr_hi_n` stays high.
- R6: With `cfg_byte_wr` = 1 on a 16-bit bus (`cfg_bus8` = 0), `wr_lo_n` goes low in the R4 window only when `req_be[0]` = 1, and `wr_hi_n` only when `req_be[1]` = 1. On an 8-bit bus, `wr_lo_n` goes low for every write and `wr_hi_n` stays high.
- R7: `bhe_n` is low for all L cycles of the access exactly when `req_be[1]` = 1 and the bus is 16 bits wide. Otherwise it stays high.
- R8: In multiplexed mode, `ad_out` carries `req_addr[15:0]` with `ad_oe` = 1 while `ale` is high. In demultiplexed mode, `ad_oe` = 0 during `ale`. In both modes, a write drives `req_wdata` with `ad_oe` = 1 for the whole command region, and a read keeps `ad_oe` = 0 after `ale`. `addr_out` holds `req_addr` throughout.
- R9: The 2·C recovery cycles after the command region have all strobes inactive and `ad_oe` = 0.
- R10: `rdata` equals the value on `ad_in` during the last cycle of the command region of a read. It is valid when `done` pulses, and `done` is high for exactly one cycle.
- R11: A `req_valid` pulse that arrives while an access is in progress is ignored. No extra access follows it, and the latched address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor rate (one TCL per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse; sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read or fetch |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 = low byte, bit 1 = high byte |
| cfg_mux | input | 1 | 1 = multiplexed address/data bus |
| cfg_ext_ale | input | 1 | 1 = extended address-latch phase |
| cfg_rw_delay | input | 1 | 1 = command strobe delayed by one cycle |
| cfg_wait | input | WAIT_W | Wait states, 2 cycles each |
| cfg_recov | input | RECOV_W | Recovery units, 2 cycles each |
| cfg_byte_wr | input | 1 | 1 = per-byte write strobes |
| cfg_bus8 | input | 1 | 1 = 8-bit bus |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Single or low-byte write strobe, active low |
| wr_hi_n | output | 1 | High-byte write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| addr_out | output | ADDR_W | Latched address lines |
| ad_out | output | 16 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 16 | Shared bus input value |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 16 | Read data, valid with `done` |

## Verification
The bench builds the sequencer with its default parameters: a 24-bit address, a 4-bit wait field and a 2-bit recovery field. With these values the longest access, 44 cycles with 15 wait states, three recovery units and the extended latch phase, runs in a short time. This brings both wait-count extremes, every recovery value, and both the delayed and undelayed strobe starts within reach in a handful of accesses. The bench changes `ad_in` every cycle, so a read-data sample taken one cycle early or late shows up as a wrong value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_DATA_W = 16;
    localparam int XB_BE_W   = XB_DATA_W / 8;

    // Command-region length in TCL without wait states
    localparam int XB_REGION_MUX   = 5;
    localparam int XB_REGION_DEMUX = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALE    = 2'd1,
        ST_STROBE = 2'd2,
        ST_RECOV  = 2'd3
    } xb_state_e;

endpackage

// File: rtl/xbus_phase_len.sv
// Derives counter reload values for the command and recovery phases
module xbus_phase_len #(
    parameter int WAIT_W  = 4,
    parameter int RECOV_W = 2,
    parameter int CNT_W   = 6
) (
    input  logic               mux,
    input  logic [WAIT_W-1:0]  wait_n,
    input  logic [RECOV_W-1:0] recov,
    output logic [CNT_W-1:0]   strobe_load,
    output logic [CNT_W-1:0]   recov_load,
    output logic               recov_zero
);
    import xbus_pkg::*;

    localparam logic [CNT_W-1:0] LOAD_MUX   = CNT_W'(XB_REGION_MUX - 1);
    localparam logic [CNT_W-1:0] LOAD_DEMUX = CNT_W'(XB_REGION_DEMUX - 1);

    logic [CNT_W-1:0] wait_tcl;
    logic [CNT_W-1:0] recov_tcl;

    always_comb begin
        wait_tcl    = CNT_W'({wait_n, 1'b0});
        recov_tcl   = CNT_W'({recov, 1'b0});
        strobe_load = (mux ? LOAD_MUX : LOAD_DEMUX) + wait_tcl;
        recov_zero  = (recov == '0);
        recov_load  = recov_tcl - CNT_W'(1);
    end

endmodule

// File: rtl/xbus_pin_drv.sv
// Pin-level output decode from the sequencer state and latched access
module xbus_pin_drv (
    input  xbus_pkg::xb_state_e state,
    input  logic        dly,
    input  logic        wr,
    input  logic        mux,
    input  logic        byte_wr,
    input  logic        bus8,
    input  logic [1:0]  be,
    input  logic [15:0] addr_lo,
    input  logic [15:0] wdata,
    output logic        ale,
    output logic        rd_n,
    output logic        wr_lo_n,
    output logic        wr_hi_n,
    output logic        bhe_n,
    output logic        ad_oe,
    output logic [15:0] ad_out
);
    import xbus_pkg::*;

    logic cmd_on;
    logic lo_act;
    logic hi_act;

    always_comb begin
        cmd_on  = (state == ST_STROBE) && !dly;
        lo_act  = wr && (!byte_wr || bus8 || be[0]);
        hi_act  = wr && byte_wr && !bus8 && be[1];

        ale     = (state == ST_ALE);
        rd_n    = !(cmd_on && !wr);
        wr_lo_n = !(cmd_on && lo_act);
        wr_hi_n = !(cmd_on && hi_act);
        bhe_n   = !((state != ST_IDLE) && be[1] && !bus8);

        unique case (state)
            ST_ALE: begin
                ad_oe  = mux;
                ad_out = addr_lo;
            end
            ST_STROBE: begin
                ad_oe  = wr;
                ad_out = wdata;
            end
            default: begin
                ad_oe  = 1'b0;
                ad_out = wdata;
            end
        endcase
    end

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl #(
    parameter int ADDR_W  = 24,
    parameter int WAIT_W  = 4,
    parameter int RECOV_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [1:0]         req_be,
    input  logic               cfg_mux,
    input  logic               cfg_ext_ale,
    input  logic               cfg_rw_delay,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [RECOV_W-1:0] cfg_recov,
    input  logic               cfg_byte_wr,
    input  logic               cfg_bus8,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_lo_n,
    output logic               wr_hi_n,
    output logic               bhe_n,
    output logic [ADDR_W-1:0]  addr_out,
    output logic [15:0]        ad_out,
    output logic               ad_oe,
    input  logic [15:0]        ad_in,
    output logic               done,
    output logic [15:0]        rdata
);
    import xbus_pkg::*;

    localparam int CNT_W = ((WAIT_W > RECOV_W) ? WAIT_W : RECOV_W) + 2;

    xb_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic               dly_q;
    logic               done_q;
    logic [15:0]        rdata_q;

    logic               wr_q, mux_q, rwdly_q, byte_q, bus8_q;
    logic [1:0]         be_q;
    logic [WAIT_W-1:0]  wait_q;
    logic [RECOV_W-1:0] recov_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [15:0]        wdata_q;

    logic [CNT_W-1:0]   strobe_load;
    logic [CNT_W-1:0]   recov_load;
    logic               recov_zero;
    logic               cnt_zero;

    assign cnt_zero = (cnt == '0);

    xbus_phase_len #(
        .WAIT_W (WAIT_W),
        .RECOV_W(RECOV_W),
        .CNT_W  (CNT_W)
    ) u_len (
        .mux        (mux_q),
        .wait_n     (wait_q),
        .recov      (recov_q),
        .strobe_load(strobe_load),
        .recov_load (recov_load),
        .recov_zero (recov_zero)
    );

    // State register, phase counter and access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            dly_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
            wr_q    <= 1'b0;
            mux_q   <= 1'b0;
            rwdly_q <= 1'b0;
            byte_q  <= 1'b0;
            bus8_q  <= 1'b0;
            be_q    <= '0;
            wait_q  <= '0;
            recov_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        mux_q   <= cfg_mux;
                        rwdly_q <= cfg_rw_delay;
                        byte_q  <= cfg_byte_wr;
                        bus8_q  <= cfg_bus8;
                        be_q    <= req_be;
                        wait_q  <= cfg_wait;
                        recov_q <= cfg_recov;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        cnt     <= cfg_ext_ale ? CNT_W'(2) : '0;
                        state   <= ST_ALE;
                    end
                end
                ST_ALE: begin
                    if (cnt_zero) begin
                        state <= ST_STROBE;
                        cnt   <= strobe_load;
                        dly_q <= rwdly_q;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_STROBE: begin
                    dly_q <= 1'b0;
                    if (cnt_zero) begin
                        if (!wr_q) begin
                            rdata_q <= ad_in;
                        end
                        if (recov_zero) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_RECOV;
                            cnt   <= recov_load;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_RECOV: begin
                    if (cnt_zero) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Output decode
    xbus_pin_drv u_pins (
        .state  (state),
        .dly    (dly_q),
        .wr     (wr_q),
        .mux    (mux_q),
        .byte_wr(byte_q),
        .bus8   (bus8_q),
        .be     (be_q),
        .addr_lo(addr_q[15:0]),
        .wdata  (wdata_q),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_lo_n(wr_lo_n),
        .wr_hi_n(wr_hi_n),
        .bhe_n  (bhe_n),
        .ad_oe  (ad_oe),
        .ad_out (ad_out)
    );

    assign addr_out = addr_q;
    assign done     = done_q;
    assign rdata    = rdata_q;

    // Assertions
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!ale && rd_n && wr_lo_n && wr_hi_n && bhe_n && !ad_oe));

    p_ale_no_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_lo_n && wr_hi_n));

    p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (wr_lo_n && wr_hi_n));

    p_single_hi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !byte_q) |-> wr_hi_n);

    p_bhe_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bhe_n |-> ((state != ST_IDLE) && !bus8_q && be_q[1]));

    p_recov_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOV) |-> (rd_n && wr_lo_n && wr_hi_n && !ad_oe));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && req_valid) |=> $stable(addr_q));

endmodule

// File: tb/xbus_cycle_ctrl_test.sv
module xbus_cycle_ctrl_test;
    localparam int ADDR_W  = 24;
    localparam int WAIT_W  = 4;
    localparam int RECOV_W = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic               req_valid, req_write;
    logic [ADDR_W-1:0]  req_addr;
    logic [15:0]        req_wdata;
    logic [1:0]         req_be;
    logic               cfg_mux, cfg_ext_ale, cfg_rw_delay, cfg_byte_wr, cfg_bus8;
    logic [WAIT_W-1:0]  cfg_wait;
    logic [RECOV_W-1:0] cfg_recov;
    logic               ale, rd_n, wr_lo_n, wr_hi_n, bhe_n, ad_oe, done;
    logic [ADDR_W-1:0]  addr_out;
    logic [15:0]        ad_out, ad_in, rdata;

    xbus_cycle_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .RECOV_W(RECOV_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_mux(cfg_mux), .cfg_ext_ale(cfg_ext_ale), .cfg_rw_delay(cfg_rw_delay),
        .cfg_wait(cfg_wait), .cfg_recov(cfg_recov), .cfg_byte_wr(cfg_byte_wr),
        .cfg_bus8(cfg_bus8), .ale(ale), .rd_n(rd_n), .wr_lo_n(wr_lo_n),
        .wr_hi_n(wr_hi_n), .bhe_n(bhe_n), .addr_out(addr_out), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .done(done), .rdata(rdata)
    );

    typedef struct packed {
        logic [7:0]        ale_len;
        logic [7:0]        st_start;
        logic [7:0]        st_len;
        logic [7:0]        cmd_end;
        logic [7:0]        total;
        logic [7:0]        oe_post;
        logic              rd, wl, wh, bhe, mux, byte_wr;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
    } exp_t;

    exp_t exp_q[$];

    int n_chk  = 0;
    int n_fail = 0;
    int tick   = 0;
    int pushed = 0;
    int rises  = 0;

    function automatic logic [15:0] pat(int k);
        return 16'(k * 37) ^ 16'hA55A;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: measures each access at the pins and scores it against the queue
    logic ale_prev = 1'b0;
    bit   in_cyc   = 1'b0;
    int   t0, ale_c, rd_c, rd_first, wl_c, wl_first, wh_c, wh_first, bhe_c, oe_c, ad_bad, rec_bad;
    logic        ale_oe;
    logic [15:0] ale_ad;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale && !ale_prev) begin
                in_cyc = 1'b1; t0 = tick; rises++;
                ale_c = 0; rd_c = 0; wl_c = 0; wh_c = 0; bhe_c = 0;
                oe_c = 0; ad_bad = 0; rec_bad = 0;
                rd_first = -1; wl_first = -1; wh_first = -1;
            end
            if (in_cyc && exp_q.size() > 0) begin
                int rel;
                rel = tick - t0;
                if (rel == 0) begin ale_oe = ad_oe; ale_ad = ad_out; end
                if (ale) ale_c++;
                if (!rd_n)    begin if (rd_c == 0) rd_first = rel; rd_c++; end
                if (!wr_lo_n) begin if (wl_c == 0) wl_first = rel; wl_c++; end
                if (!wr_hi_n) begin if (wh_c == 0) wh_first = rel; wh_c++; end
                if (!bhe_n) bhe_c++;
                if (!ale && ad_oe && rel < int'(exp_q[0].cmd_end)) oe_c++;
                if ((!wr_lo_n || !wr_hi_n) && !(ad_oe && ad_out == exp_q[0].wdata)) ad_bad++;
                if (rel >= int'(exp_q[0].cmd_end) && (!rd_n || !wr_lo_n || !wr_hi_n || ad_oe)) rec_bad++;
                if (addr_out != exp_q[0].addr) ad_bad++;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 done without accepted request", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(ale_c == int'(e.ale_len), "R3 ale length", ale_c, int'(e.ale_len));
                    check(tick - t0 == int'(e.total), "R2 access length", tick - t0, int'(e.total));
                    if (e.rd) begin
                        check(rd_c == int'(e.st_len), "R4 read strobe length", rd_c, int'(e.st_len));
                        check(rd_first == int'(e.st_start), "R4 read strobe start", rd_first, int'(e.st_start));
                        check(rdata == pat(t0 + int'(e.cmd_end) - 1), "R10 read data sample",
                              int'(rdata), int'(pat(t0 + int'(e.cmd_end) - 1)));
                    end else begin
                        check(rd_c == 0, "R4 no read strobe on write", rd_c, 0);
                    end
                    if (e.wl) begin
                        check(wl_c == int'(e.st_len) && wl_first == int'(e.st_start),
                              e.byte_wr ? "R6 low write strobe window" : "R5 write strobe window",
                              wl_c, int'(e.st_len));
                    end else begin
                        check(wl_c == 0, e.byte_wr ? "R6 low write strobe quiet" : "R5 write strobe quiet", wl_c, 0);
                    end
                    if (e.wh) begin
                        check(wh_c == int'(e.st_len) && wh_first == int'(e.st_start),
                              "R6 high write strobe window", wh_c, int'(e.st_len));
                    end else begin
                        check(wh_c == 0, e.byte_wr ? "R6 high write strobe quiet" : "R5 high strobe unused", wh_c, 0);
                    end
                    check(bhe_c == (e.bhe ? int'(e.total) : 0), "R7 high byte enable", bhe_c,
                          e.bhe ? int'(e.total) : 0);
                    check(e.mux ? (ale_oe && ale_ad == e.addr[15:0]) : !ale_oe, "R8 address phase on shared bus",
                          int'(ale_ad), e.mux ? int'(e.addr[15:0]) : 0);
                    check(oe_c == int'(e.oe_post) && ad_bad == 0, "R8 data phase drive", oe_c, int'(e.oe_post));
                    check(rec_bad == 0, "R9 recovery quiet", rec_bad, 0);
                end
                in_cyc = 1'b0;
            end
        end
        ale_prev = ale;
        ad_in    = pat(tick);
        tick++;
    end

    // Driver: issues one access, pushes its expectation, waits for completion
    task automatic issue(bit wr, logic [ADDR_W-1:0] a, logic [15:0] d, logic [1:0] be,
                         bit mux, bit ext, bit dly, int w, int r, bit bw, bit b8, bit intrude);
        exp_t e;
        int region;
        region     = (mux ? 5 : 3) + 2 * w;
        e.ale_len  = 8'(1 + 2 * ext);
        e.st_start = 8'(1 + 2 * ext + dly);
        e.st_len   = 8'(region - dly);
        e.cmd_end  = 8'(1 + 2 * ext + region);
        e.total    = 8'(1 + 2 * ext + region + 2 * r);
        e.oe_post  = wr ? 8'(region) : 8'd0;
        e.rd       = !wr;
        e.wl       = wr && (!bw || b8 || be[0]);
        e.wh       = wr && bw && !b8 && be[1];
        e.bhe      = be[1] && !b8;
        e.mux      = mux;
        e.byte_wr  = bw;
        e.addr     = a;
        e.wdata    = d;
        exp_q.push_back(e);
        pushed++;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        cfg_mux = mux; cfg_ext_ale = ext; cfg_rw_delay = dly;
        cfg_wait = WAIT_W'(w); cfg_recov = RECOV_W'(r); cfg_byte_wr = bw; cfg_bus8 = b8;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_addr = ~a; req_write = !wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tick, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        req_be = 2'b11; cfg_mux = 1'b0; cfg_ext_ale = 1'b0; cfg_rw_delay = 1'b0;
        cfg_wait = '0; cfg_recov = '0; cfg_byte_wr = 1'b0; cfg_bus8 = 1'b0; ad_in = '0;
        repeat (3) @(negedge clk);
        check(!ale && rd_n && wr_lo_n && wr_hi_n && bhe_n && !ad_oe && !done,
              "R1 outputs during reset", int'({ale, rd_n, wr_lo_n, wr_hi_n, bhe_n, ad_oe, done}), 'b0111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!ale && rd_n && wr_lo_n && wr_hi_n && bhe_n && !ad_oe && !done,
              "R1 idle after reset", int'({ale, rd_n, wr_lo_n, wr_hi_n, bhe_n, ad_oe, done}), 'b0111100);

        // mux read, minimum cycle
        issue(0, 24'h12_3456, 16'h0, 2'b11, 1, 0, 0, 0, 0, 0, 0, 0);
        // demux read, minimum cycle
        issue(0, 24'hAB_CDEF, 16'h0, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
        // mux single-write, extended latch, delay, waits, recovery
        issue(1, 24'h00_1F2E, 16'hBEEF, 2'b11, 1, 1, 1, 2, 1, 0, 0, 0);
        // single-write of high byte only
        issue(1, 24'h3C_0001, 16'h1234, 2'b10, 0, 0, 0, 1, 0, 0, 0, 0);
        // per-byte writes on 16-bit bus
        issue(1, 24'h55_0010, 16'hA0B0, 2'b10, 0, 0, 1, 0, 2, 1, 0, 0);
        issue(1, 24'h55_0012, 16'hC0D0, 2'b01, 1, 0, 0, 3, 0, 1, 0, 0);
        issue(1, 24'h55_0014, 16'hE0F0, 2'b11, 0, 1, 0, 0, 1, 1, 0, 0);
        // per-byte mode on 8-bit bus
        issue(1, 24'h66_0020, 16'h0F0F, 2'b11, 1, 0, 1, 0, 0, 1, 1, 0);
        // longest cycle, demux read
        issue(0, 24'h7F_FFFE, 16'h0, 2'b11, 0, 1, 1, 15, 3, 0, 0, 0);
        // mux read with delay and 8-bit bus
        issue(0, 24'h01_0203, 16'h0, 2'b11, 1, 0, 1, 4, 2, 1, 1, 0);
        // request arriving while busy
        issue(1, 24'h44_4444, 16'h5AA5, 2'b11, 1, 0, 0, 3, 1, 0, 0, 1);
        repeat (8) @(negedge clk);
        check(rises == pushed, "R11 busy request ignored", rises, pushed);
        check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule